// File: doc/BRIEF.md
# Shared Video RAM Time-Slice Arbiter

This block shares one video/character RAM between a CPU and a CRT controller, and takes all of its timing from a single dot clock. It counts dot clocks through a repeating slot period of `2*CPU_DIV` dots. From that count it makes the CPU clock, which is the dot clock divided by `CPU_DIV`. It also makes the controller clock, which is the CPU clock divided by two. In the high half of each controller period the RAM belongs to the controller. In the low half it belongs to the CPU. The controller therefore gets exactly one RAM slot in every one of its cycles, whatever the CPU is doing. Because the two owners never overlap, the display never glitches, and the CPU never has to wait for flyback.

A load strobe marks the last dot of each controller half, so that the display path captures the fetched video data. The CPU may issue a memory request to the upper half of its address space, which holds the video region. If that request falls in the controller half, the block drives the CPU wait line low until the CPU half starts. Requests to the lower half of the address space never wait. A data-bus enable opens the CPU data path only during a CPU half in which a video request is present.

Every output is registered. All outputs describe the same phase, which the bench can track by counting dot clocks from the release of reset. The phase numbering used below is: the first dot after reset is phase 0, the phase rises by one on each dot, and it wraps from `2*CPU_DIV-1` back to 0. HALF equals `CPU_DIV`.

Top module: `vram_slice_arb`

## Requirements
- R1: `cpu_clk` is 1 when (phase mod `CPU_DIV`) < `CPU_DIV/2`, and 0 otherwise.
- R2: `ctl_clk` is 1 in phases 0..HALF-1 and 0 in phases HALF..2*HALF-1.
- R3: `ram_sel_ctl` is 1 (RAM given to the controller) in phases 0..HALF-1 and 0 (RAM given to the CPU) in the other phases.
- R4: `load_n` is 0 only in phase HALF-1, which is the last dot of the controller half.
- R5: A request is sampled on a dot clock edge where `cpu_mreq_n`=0 and `cpu_a_top`=1. If the phase entered at that edge is below HALF, `wait_n` is 0 in that phase.
- R6: `wait_n` stays 1 whenever `cpu_a_top`=0 or `cpu_mreq_n`=1 was sampled at the edge. These are full-speed accesses.
- R7: `cpu_data_en` is 1 exactly when a video request was sampled and the phase entered is HALF or higher.
- R8: While `rst`=1, the outputs hold these values: `cpu_clk`=0, `ctl_clk`=0, `ram_sel_ctl`=1, `load_n`=1, `wait_n`=1, `cpu_data_en`=0. The first edge with `rst`=0 enters phase 0, which is a controller-high phase.
- R9: In every slot period, `ram_sel_ctl` is 1 for exactly HALF dots, even under a continuous CPU video request.
- R10: `wait_n` is never 0 for more than HALF consecutive dot clocks. That is one CPU clock, or half a controller period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_mreq_n | input | 1 | CPU memory request, active low |
| cpu_a_top | input | 1 | Most significant CPU address line (1 = video region) |
| cpu_clk | output | 1 | Derived CPU clock |
| ctl_clk | output | 1 | Derived CRT controller clock |
| ram_sel_ctl | output | 1 | RAM mux select: 1 = controller, 0 = CPU |
| load_n | output | 1 | Active-low latch strobe for fetched video data |
| wait_n | output | 1 | Active-low CPU wait |
| cpu_data_en | output | 1 | CPU data-bus enable toward the RAM |

## Verification
The hardest case to reach is a video request that arrives at each possible phase of the slot period, including the case where the request stays asserted across the boundary from the CPU half into the controller half. That case gives the longest stall. The bench holds each request combination for several whole periods, then runs a request pattern whose repeat length is prime relative to the period, so that every start phase occurs. It then applies a long unbroken video request that runs through both halves. A mid-run reset confirms that phase alignment restarts at the controller half.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Outputs that belong to one slot phase
  typedef struct packed {
    logic cpu_clk;
    logic ctl_clk;
    logic sel_ctl;
    logic load_n;
  } slot_sig_t;

  localparam slot_sig_t SLOT_RST = '{cpu_clk: 1'b0, ctl_clk: 1'b0, sel_ctl: 1'b1, load_n: 1'b1};
endpackage

// File: rtl/arb_phase_gen.sv
module arb_phase_gen #(
  parameter int CPU_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic nxt_ctl_half,
  output arb_pkg::slot_sig_t sig_o
);
  import arb_pkg::*;
  localparam int HALF = CPU_DIV;
  localparam int P    = 2 * CPU_DIV;
  localparam int PW   = $clog2(P);
  localparam logic [PW-1:0] LAST = PW'(P - 1);
  localparam logic [PW-1:0] HALF_V = PW'(HALF);
  localparam logic [PW-1:0] LOAD_PH = PW'(HALF - 1);
  localparam int SW = (CPU_DIV > 2) ? $clog2(CPU_DIV) : 1;

  logic [PW-1:0] ph, ph_n;
  logic [SW-1:0] sub_n;
  slot_sig_t     sig_n;

  always_comb begin
    ph_n  = (ph == LAST) ? '0 : ph + 1'b1;
    sub_n = SW'(int'(ph_n) % CPU_DIV);
    sig_n.cpu_clk = (int'(sub_n) < CPU_DIV / 2);
    sig_n.ctl_clk = (ph_n < HALF_V);
    sig_n.sel_ctl = (ph_n < HALF_V);
    sig_n.load_n  = (ph_n != LOAD_PH);
  end

  assign nxt_ctl_half = (ph_n < HALF_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= LAST;
      sig_o <= SLOT_RST;
    end else begin
      ph    <= ph_n;
      sig_o <= sig_n;
    end
  end

  // ctl_clk may change only when the phase crosses a half boundary
  p_ctl_edges_r2: assert property (@(posedge clk) disable iff (rst)
    (ph != LOAD_PH && ph != LAST) |=> $stable(sig_o.ctl_clk));
  // The load strobe falls only inside the controller half
  p_load_in_ctl_r4: assert property (@(posedge clk) disable iff (rst)
    !sig_o.load_n |-> sig_o.sel_ctl);
endmodule

// File: rtl/arb_wait_ctl.sv
module arb_wait_ctl (
  input  logic clk,
  input  logic rst,
  input  logic mreq_n,
  input  logic a_top,
  input  logic nxt_ctl_half,
  output logic wait_n_o,
  output logic den_o
);
  logic vid_req;
  assign vid_req = !mreq_n && a_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_n_o <= 1'b1;
      den_o    <= 1'b0;
    end else begin
      wait_n_o <= !(vid_req && nxt_ctl_half);
      den_o    <= vid_req && !nxt_ctl_half;
    end
  end

  // Wait only ever follows a sampled video-region request
  p_wait_src_r6: assert property (@(posedge clk) disable iff (rst)
    !wait_n_o |-> $past(!mreq_n && a_top));
  // Data enable only ever follows a sampled video-region request
  p_den_src_r7: assert property (@(posedge clk) disable iff (rst)
    den_o |-> $past(!mreq_n && a_top));
endmodule

// File: rtl/vram_slice_arb.sv
module vram_slice_arb #(
  parameter int CPU_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cpu_mreq_n,
  input  logic cpu_a_top,
  output logic cpu_clk,
  output logic ctl_clk,
  output logic ram_sel_ctl,
  output logic load_n,
  output logic wait_n,
  output logic cpu_data_en
);
  import arb_pkg::*;
  localparam int CW = $clog2(2 * CPU_DIV + 2);

  slot_sig_t sig;
  logic      nxt_ctl_half;

  arb_phase_gen #(.CPU_DIV(CPU_DIV)) u_phase (
    .clk(clk), .rst(rst), .nxt_ctl_half(nxt_ctl_half), .sig_o(sig)
  );

  arb_wait_ctl u_wait (
    .clk(clk), .rst(rst), .mreq_n(cpu_mreq_n), .a_top(cpu_a_top),
    .nxt_ctl_half(nxt_ctl_half), .wait_n_o(wait_n), .den_o(cpu_data_en)
  );

  assign cpu_clk     = sig.cpu_clk;
  assign ctl_clk     = sig.ctl_clk;
  assign ram_sel_ctl = sig.sel_ctl;
  assign load_n      = sig.load_n;

  // Checker-only run length of wait
  logic [CW-1:0] stall_cnt;
  always_ff @(posedge clk) begin
    if (rst)          stall_cnt <= '0;
    else if (!wait_n) stall_cnt <= stall_cnt + 1'b1;
    else              stall_cnt <= '0;
  end

  p_stall_bound_r10: assert property (@(posedge clk) disable iff (rst)
    int'(stall_cnt) <= CPU_DIV);
  p_den_cpu_half_r7: assert property (@(posedge clk) disable iff (rst)
    cpu_data_en |-> !ram_sel_ctl);
  p_wait_ctl_half_r5: assert property (@(posedge clk) disable iff (rst)
    !wait_n |-> ram_sel_ctl);
  p_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(cpu_data_en && !wait_n));
endmodule

// File: tb/sim_vram_slice_arb.sv
module sim_vram_slice_arb;
  localparam int TCLK = 10;
  localparam int DIV  = 4;
  localparam int HALF = DIV;
  localparam int P    = 2 * DIV;

  logic clk = 1'b0, rst = 1'b1, mreq_n = 1'b1, a_top = 1'b0;
  logic cpu_clk, ctl_clk, sel, load_n, wait_n, den;
  int total = 0, bad = 0;
  int ph_e = P - 1;
  int stall = 0, sel_cnt = 0;
  bit done = 0;

  vram_slice_arb #(.CPU_DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .cpu_mreq_n(mreq_n), .cpu_a_top(a_top),
    .cpu_clk(cpu_clk), .ctl_clk(ctl_clk), .ram_sel_ctl(sel), .load_n(load_n),
    .wait_n(wait_n), .cpu_data_en(den)
  );

  always #(TCLK/2) clk = ~clk;

  task automatic chk(input logic got, input logic exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s phase=%0d got=%b exp=%b", tag, ph_e, got, exp);
    end
  endtask

  task automatic chk_int(input int got, input int exp, input string tag);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // Drive at negedge, let one edge pass, check at the following negedge
  task automatic step(input logic rq_n, input logic at);
    logic vid;
    mreq_n = rq_n;
    a_top  = at;
    vid = !rq_n && at;
    @(posedge clk);
    ph_e = (ph_e == P - 1) ? 0 : ph_e + 1;
    @(negedge clk);
    chk(cpu_clk, (ph_e % DIV) < DIV / 2, "R1 cpu_clk");
    chk(ctl_clk, ph_e < HALF, "R2 ctl_clk");
    chk(sel, ph_e < HALF, "R3 ram_sel_ctl");
    chk(load_n, ph_e != HALF - 1, "R4 load_n");
    if (vid) chk(wait_n, !(ph_e < HALF), "R5 wait_n video");
    else     chk(wait_n, 1'b1, "R6 wait_n full speed");
    chk(den, vid && ph_e >= HALF, "R7 cpu_data_en");
    stall = wait_n ? 0 : stall + 1;
    if (stall > HALF) chk_int(stall, HALF, "R10 stall length");
    if (sel) sel_cnt++;
    if (ph_e == P - 1) begin
      chk_int(sel_cnt, HALF, "R9 controller slot per period");
      sel_cnt = 0;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(cpu_clk, 1'b0, "R8 reset cpu_clk");
    chk(ctl_clk, 1'b0, "R8 reset ctl_clk");
    chk(sel, 1'b1, "R8 reset sel");
    chk(load_n, 1'b1, "R8 reset load_n");
    chk(wait_n, 1'b1, "R8 reset wait_n");
    chk(den, 1'b0, "R8 reset den");
    ph_e = P - 1; sel_cnt = 0; stall = 0;
    rst = 1'b0;
    step(1'b1, 1'b0);
    chk(ctl_clk, 1'b1, "R8 first phase controller high");
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 2 * P; i++) step(c[0], c[1]);
    for (int i = 0; i < 77; i++) step((i % 3) == 0, (i % 5) < 3);
    for (int i = 0; i < 4 * P; i++) step(1'b0, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1);
    do_reset();
    for (int i = 0; i < 3 * P; i++) step((i % 7) == 2, 1'b1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule